// File: doc/BRIEF.md
# Single-Bit Ladder Logic Engine

A small sequential engine that solves Boolean relay-ladder networks, one instruction per clock. It fetches from an external program memory whose read is combinational: the engine drives an address and gets a 4-bit opcode plus an operand bit index in the same cycle. All work is done in a one-bit result accumulator. Results of parallel or series branches that are not yet complete are saved on a one-bit last-in first-out stack. They are merged back later with block AND and block OR operations.

Scans have snapshot semantics. When a scan starts, every input pin is copied into an input image. All instructions read that image and write a separate output image. The output pins change only when the end-of-scan instruction executes, and then they all change together. For example, Y0 = (X0·X1) + (X2·X3) is solved in three steps: evaluate the first branch and push it, evaluate the second branch, then apply block OR.

Top module: `ladder_engine`

## Requirements
- R1: After reset, `outPins`, `scanDone`, `stackErr` and `pgmAddr` are all zero.
- R2: Opcodes are: 0 end-of-scan, 1 start-rung, 2 load, 3 load-inverted, 4 AND, 5 AND-inverted, 6 OR, 7 OR-inverted, 8 XOR, 9 XOR-inverted, 10 output, 11 output-inverted, 12 push, 13 block-AND, 14 block-OR. Opcode 15 does nothing. Start-rung clears the accumulator, so no result carries from one rung to the next.
- R3: Load copies input-image bit `pgmIdx` into the accumulator. AND, OR and XOR combine the accumulator with that bit, and any number of them may be chained.
- R4: Each of the odd opcodes 3, 5, 7 and 9 complements its input operand before the operation.
- R5: Output writes the accumulator into output-image bit `pgmIdx`. Output-inverted writes its complement. Output-image bits that are not written keep their value from one scan to the next.
- R6: Push saves the accumulator on top of the stack. Block-AND and block-OR pop the most recently pushed entry and combine it with the accumulator, which keeps the result (last-in first-out order).
- R7: A push when STACK_DEPTH entries are already held sets `stackErr` and leaves the stack contents and level unchanged.
- R8: Block-AND or block-OR on an empty stack sets `stackErr` and leaves both the accumulator and the stack unchanged.
- R9: The input image is captured once, on the cycle a scan starts. An input change during a scan has no effect on that scan's results.
- R10: End-of-scan copies the output image to `outPins` on the same clock edge that raises `scanDone` for exactly one cycle. Fetching then restarts at address 0. `outPins` changes at no other time.
- R11: The stack level returns to zero at every scan start.
- R12: `stackErr` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Start a scan when idle |
| pgmAddr | output | ADDR_W | Program memory address |
| pgmOp | input | 4 | Opcode at `pgmAddr` |
| pgmIdx | input | IDX_W | Operand bit index at `pgmAddr` |
| inPins | input | NUM_IN | Input pins |
| outPins | output | NUM_OUT | Committed output pins |
| scanDone | output | 1 | One-cycle pulse when a scan commits |
| stackErr | output | 1 | Sticky stack overflow or underflow flag |

## Verification
The bench uses the default parameters: 32 inputs, 32 outputs, a 32-entry stack and a 64-word program space. With the full 32-entry stack, an overflow program of 39 instructions fits in the program space, so a 33rd push can be tried and the entry underneath checked by popping it afterwards. With 32 inputs and outputs, the bench can keep spare pins at constant levels and dedicate separate output bits to each gate form, so one scan checks many functions at once.

// File: rtl/ladder_pkg.sv
package ladder_pkg;

  typedef enum logic [3:0] {
    OP_END  = 4'd0,
    OP_RUNG = 4'd1,
    OP_LD   = 4'd2,
    OP_LDN  = 4'd3,
    OP_AND  = 4'd4,
    OP_ANDN = 4'd5,
    OP_OR   = 4'd6,
    OP_ORN  = 4'd7,
    OP_XOR  = 4'd8,
    OP_XORN = 4'd9,
    OP_OUT  = 4'd10,
    OP_OUTN = 4'd11,
    OP_PUSH = 4'd12,
    OP_BAND = 4'd13,
    OP_BOR  = 4'd14,
    OP_NOP  = 4'd15
  } ladderOp_e;

  typedef enum logic [1:0] {
    LG_LD  = 2'd0,
    LG_AND = 2'd1,
    LG_OR  = 2'd2,
    LG_XOR = 2'd3
  } logicOp_e;

  typedef struct packed {
    logic     snap;
    logic     clrAcc;
    logic     logicEn;
    logicOp_e logicOp;
    logic     invIn;
    logic     outEn;
    logic     invOut;
    logic     push;
    logic     blkEn;
    logic     blkOr;
    logic     commit;
  } strobes_t;

endpackage

// File: rtl/ladder_ctrl.sv
module ladder_ctrl
  import ladder_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              run,
  input  logic [3:0]        pgmOp,
  output logic [ADDR_W-1:0] pc,
  output strobes_t          stb,
  output logic              scanDone
);

  typedef enum logic {ST_IDLE, ST_EXEC} state_e;
  state_e state;

  always_comb begin
    stb = '0;
    stb.logicOp = LG_LD;
    if (state == ST_IDLE) begin
      stb.snap   = run;
      stb.clrAcc = run;
    end else begin
      unique case (ladderOp_e'(pgmOp))
        OP_END:  stb.commit = 1'b1;
        OP_RUNG: stb.clrAcc = 1'b1;
        OP_LD, OP_LDN: begin
          stb.logicEn = 1'b1; stb.logicOp = LG_LD;  stb.invIn = pgmOp[0];
        end
        OP_AND, OP_ANDN: begin
          stb.logicEn = 1'b1; stb.logicOp = LG_AND; stb.invIn = pgmOp[0];
        end
        OP_OR, OP_ORN: begin
          stb.logicEn = 1'b1; stb.logicOp = LG_OR;  stb.invIn = pgmOp[0];
        end
        OP_XOR, OP_XORN: begin
          stb.logicEn = 1'b1; stb.logicOp = LG_XOR; stb.invIn = pgmOp[0];
        end
        OP_OUT:  stb.outEn = 1'b1;
        OP_OUTN: begin stb.outEn = 1'b1; stb.invOut = 1'b1; end
        OP_PUSH: stb.push = 1'b1;
        OP_BAND: stb.blkEn = 1'b1;
        OP_BOR:  begin stb.blkEn = 1'b1; stb.blkOr = 1'b1; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      pc       <= '0;
      scanDone <= 1'b0;
    end else begin
      scanDone <= 1'b0;
      if (state == ST_IDLE) begin
        pc <= '0;
        if (run) state <= ST_EXEC;
      end else if (stb.commit) begin
        state    <= ST_IDLE;
        pc       <= '0;
        scanDone <= 1'b1;
      end else begin
        pc <= pc + 1'b1;
      end
    end
  end

endmodule

// File: rtl/ladder_bitstack.sv
module ladder_bitstack #(
  parameter int DEPTH = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clear,
  input  logic             push,
  input  logic             pop,
  input  logic             dataIn,
  output logic             topBit,
  output logic             empty,
  output logic             full,
  output logic [LVL_W-1:0] level
);

  logic [DEPTH-1:0] bits;
  logic [LVL_W-1:0] levelM1;
  logic [PTR_W-1:0] wrPtr, rdPtr;

  assign levelM1 = level - 1'b1;
  assign wrPtr   = level[PTR_W-1:0];
  assign rdPtr   = levelM1[PTR_W-1:0];
  assign empty   = (level == '0);
  assign full    = (level == LVL_W'(DEPTH));
  assign topBit  = bits[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      level <= '0;
      bits  <= '0;
    end else if (clear) begin
      level <= '0;
    end else if (push && !full) begin
      bits[wrPtr] <= dataIn;
      level       <= level + 1'b1;
    end else if (pop && !empty) begin
      level <= levelM1;
    end
  end

endmodule

// File: rtl/ladder_dp.sv
module ladder_dp
  import ladder_pkg::*;
#(
  parameter int NUM_IN      = 32,
  parameter int NUM_OUT     = 32,
  parameter int IDX_W       = 5,
  parameter int STACK_DEPTH = 32,
  localparam int LVL_W      = $clog2(STACK_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobes_t           stb,
  input  logic [IDX_W-1:0]   idx,
  input  logic [NUM_IN-1:0]  inPins,
  output logic [NUM_OUT-1:0] outPins,
  output logic               stackErr,
  output logic [LVL_W-1:0]   stackLevel
);

  logic [NUM_IN-1:0]  inImage;
  logic [NUM_OUT-1:0] outImage;
  logic acc, accNext, operand, selBit;
  logic topBit, stkEmpty, stkFull;

  always_comb begin
    selBit = 1'b0;
    for (int i = 0; i < NUM_IN; i++)
      if (idx == IDX_W'(i)) selBit = inImage[i];
    operand = selBit ^ stb.invIn;
  end

  always_comb begin
    accNext = acc;
    if (stb.clrAcc) begin
      accNext = 1'b0;
    end else if (stb.logicEn) begin
      unique case (stb.logicOp)
        LG_LD:   accNext = operand;
        LG_AND:  accNext = acc & operand;
        LG_OR:   accNext = acc | operand;
        default: accNext = acc ^ operand;
      endcase
    end else if (stb.blkEn && !stkEmpty) begin
      accNext = stb.blkOr ? (acc | topBit) : (acc & topBit);
    end
  end

  ladder_bitstack #(.DEPTH(STACK_DEPTH)) stack_i (
    .clk    (clk),
    .rstN   (rstN),
    .clear  (stb.snap),
    .push   (stb.push),
    .pop    (stb.blkEn),
    .dataIn (acc),
    .topBit (topBit),
    .empty  (stkEmpty),
    .full   (stkFull),
    .level  (stackLevel)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc      <= 1'b0;
      inImage  <= '0;
      outImage <= '0;
      outPins  <= '0;
      stackErr <= 1'b0;
    end else begin
      acc <= accNext;
      if (stb.snap) inImage <= inPins;
      if (stb.outEn) begin
        for (int j = 0; j < NUM_OUT; j++)
          if (idx == IDX_W'(j)) outImage[j] <= acc ^ stb.invOut;
      end
      if (stb.commit) outPins <= outImage;
      if ((stb.push && stkFull) || (stb.blkEn && stkEmpty)) stackErr <= 1'b1;
    end
  end

endmodule

// File: rtl/ladder_engine.sv
module ladder_engine
  import ladder_pkg::*;
#(
  parameter int NUM_IN      = 32,
  parameter int NUM_OUT     = 32,
  parameter int IDX_W       = 5,
  parameter int STACK_DEPTH = 32,
  parameter int ADDR_W      = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               run,
  output logic [ADDR_W-1:0]  pgmAddr,
  input  logic [3:0]         pgmOp,
  input  logic [IDX_W-1:0]   pgmIdx,
  input  logic [NUM_IN-1:0]  inPins,
  output logic [NUM_OUT-1:0] outPins,
  output logic               scanDone,
  output logic               stackErr
);

  localparam int LVL_W = $clog2(STACK_DEPTH + 1);

  strobes_t         stb;
  logic [LVL_W-1:0] stackLevel;

  ladder_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .run      (run),
    .pgmOp    (pgmOp),
    .pc       (pgmAddr),
    .stb      (stb),
    .scanDone (scanDone)
  );

  ladder_dp #(
    .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .IDX_W(IDX_W), .STACK_DEPTH(STACK_DEPTH)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .idx        (pgmIdx),
    .inPins     (inPins),
    .outPins    (outPins),
    .stackErr   (stackErr),
    .stackLevel (stackLevel)
  );

endmodule

// File: rtl/ladder_engine_chk.sv
module ladder_engine_chk #(
  parameter int NUM_OUT = 32,
  parameter int DEPTH   = 32,
  parameter int ADDR_W  = 6,
  localparam int LVL_W  = $clog2(DEPTH + 1)
) (
  input logic               clk,
  input logic               rstN,
  input logic               scanDone,
  input logic               stackErr,
  input logic [NUM_OUT-1:0] outPins,
  input logic [ADDR_W-1:0]  pgmAddr,
  input logic [LVL_W-1:0]   stackLevel
);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    scanDone |=> !scanDone);

  assert_out_commit_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(outPins) |-> scanDone);

  assert_fetch_restart_R10: assert property (@(posedge clk) disable iff (!rstN)
    scanDone |-> (pgmAddr == '0));

  assert_err_sticky_R12: assert property (@(posedge clk) disable iff (!rstN)
    stackErr |=> stackErr);

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    stackLevel <= LVL_W'(DEPTH));

  assert_level_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stackLevel > $past(stackLevel)) |-> (stackLevel == $past(stackLevel) + 1'b1));

endmodule

bind ladder_engine ladder_engine_chk #(
  .NUM_OUT(NUM_OUT), .DEPTH(STACK_DEPTH), .ADDR_W(ADDR_W)
) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .scanDone   (scanDone),
  .stackErr   (stackErr),
  .outPins    (outPins),
  .pgmAddr    (pgmAddr),
  .stackLevel (stackLevel)
);

// File: tb/ladder_engine_tb_top.sv
module ladder_engine_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NIN = 32, NOUT = 32, IW = 5, AW = 6, PSIZE = 64;

  localparam logic [3:0] C_END = 0, C_RUNG = 1, C_LD = 2, C_LDN = 3, C_AND = 4,
    C_ANDN = 5, C_OR = 6, C_ORN = 7, C_XOR = 8, C_XORN = 9, C_OUT = 10,
    C_OUTN = 11, C_PUSH = 12, C_BAND = 13, C_BOR = 14;

  logic clk = 1'b0, rstN = 1'b0, run = 1'b0;
  logic [AW-1:0]   pgmAddr;
  logic [3:0]      pgmOp;
  logic [IW-1:0]   pgmIdx;
  logic [NIN-1:0]  inPins = '0;
  logic [NOUT-1:0] outPins;
  logic scanDone, stackErr;

  logic [3:0]    memOp  [PSIZE];
  logic [IW-1:0] memIdx [PSIZE];
  int wp;
  int nChecks = 0, nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign pgmOp  = memOp[pgmAddr];
  assign pgmIdx = memIdx[pgmAddr];

  ladder_engine dut_i (
    .clk(clk), .rstN(rstN), .run(run), .pgmAddr(pgmAddr), .pgmOp(pgmOp),
    .pgmIdx(pgmIdx), .inPins(inPins), .outPins(outPins),
    .scanDone(scanDone), .stackErr(stackErr)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clearPgm();
    for (int i = 0; i < PSIZE; i++) begin memOp[i] = C_END; memIdx[i] = '0; end
    wp = 0;
  endtask

  task automatic put(logic [3:0] op, int idx);
    memOp[wp] = op; memIdx[wp] = IW'(idx); wp++;
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0; run = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // Starts a scan and waits at a falling edge until scanDone is seen.
  task automatic runScan(string req);
    int n = 0;
    run = 1'b1;
    @(negedge clk);
    while (!scanDone && n < 500) begin @(negedge clk); n++; end
    run = 1'b0;
    if (!scanDone) check({req, " scan timeout"}, 0, 1);
  endtask

  task automatic tResetState();
    doReset();
    check("R1 outPins", outPins, 0);
    check("R1 scanDone", scanDone, 0);
    check("R1 stackErr", stackErr, 0);
    check("R1 pgmAddr", pgmAddr, 0);
  endtask

  // Y0=(X0&X1)|(X2&X3) via push/block-OR; Y9=(X0|X1)&(X2|X3) via block-AND;
  // Y7 = X0&X1&X2 chain, Y8 = X1|X2^X3 chain.
  task automatic tBranches();
    logic [NOUT-1:0] exp;
    clearPgm();
    put(C_LD,0); put(C_AND,1); put(C_PUSH,0); put(C_RUNG,0);
    put(C_LD,2); put(C_AND,3); put(C_BOR,0); put(C_OUT,0);
    put(C_RUNG,0); put(C_LD,0); put(C_OR,1); put(C_PUSH,0);
    put(C_LD,2); put(C_OR,3); put(C_BAND,0); put(C_OUT,9);
    put(C_RUNG,0); put(C_LD,0); put(C_AND,1); put(C_AND,2); put(C_OUT,7);
    put(C_RUNG,0); put(C_LD,1); put(C_OR,2); put(C_XOR,3); put(C_OUT,8);
    put(C_END,0);
    doReset();
    for (int v = 0; v < 16; v++) begin
      inPins = NIN'(v);
      runScan("R6");
      exp = '0;
      exp[0] = (inPins[0] & inPins[1]) | (inPins[2] & inPins[3]);
      exp[9] = (inPins[0] | inPins[1]) & (inPins[2] | inPins[3]);
      exp[7] = inPins[0] & inPins[1] & inPins[2];
      exp[8] = (inPins[1] | inPins[2]) ^ inPins[3];
      check("R6 R3 branch/chain outputs", outPins, exp);
      check("R6 no error on balanced stack", stackErr, 0);
    end
  endtask

  // Inverted operands and inverted outputs, LIFO order, rung clearing.
  task automatic tInversions();
    logic [NOUT-1:0] exp;
    clearPgm();
    put(C_LD,0); put(C_ANDN,1); put(C_OUT,2);
    put(C_LD,0); put(C_OR,1); put(C_OUTN,3);
    put(C_LD,0); put(C_XOR,1); put(C_OUTN,4);
    put(C_LDN,0); put(C_ORN,1); put(C_OUT,5);
    put(C_LD,0); put(C_XORN,1); put(C_OUT,6);
    put(C_LD,0); put(C_PUSH,0); put(C_LD,1); put(C_PUSH,0);
    put(C_LD,31); put(C_BOR,0); put(C_OUT,10);
    put(C_LD,31); put(C_BOR,0); put(C_OUT,11);
    put(C_LDN,31); put(C_RUNG,0); put(C_OR,31); put(C_OUT,12);
    put(C_END,0);
    doReset();
    for (int v = 0; v < 4; v++) begin
      inPins = NIN'(v);
      runScan("R4");
      exp = '0;
      exp[2]  = inPins[0] & ~inPins[1];
      exp[3]  = ~(inPins[0] | inPins[1]);
      exp[4]  = ~(inPins[0] ^ inPins[1]);
      exp[5]  = ~inPins[0] | ~inPins[1];
      exp[6]  = inPins[0] ^ ~inPins[1];
      exp[10] = inPins[1];
      exp[11] = inPins[0];
      exp[12] = 1'b0;
      check("R4 R5 R6 R2 inverted forms, LIFO order, rung clear", outPins, exp);
    end
  endtask

  // Bits not written keep value; later writes overwrite only their bit.
  task automatic tRetain();
    clearPgm();
    put(C_LDN,31); put(C_OUT,20); put(C_OUT,21); put(C_END,0);
    doReset();
    runScan("R5");
    check("R5 first writes", outPins, 32'h0030_0000);
    clearPgm();
    put(C_LD,31); put(C_OUT,21); put(4'd15,0); put(C_END,0);
    runScan("R5");
    check("R5 unwritten bit retained, opcode 15 idle", outPins, 32'h0010_0000);
  endtask

  task automatic tSnapshot();
    clearPgm();
    for (int i = 0; i < 6; i++) put(C_RUNG,0);
    put(C_LD,0); put(C_OUT,0); put(C_END,0);
    doReset();
    inPins = 32'h1;
    run = 1'b1;
    @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    inPins = 32'h0;
    @(negedge clk);
    check("R10 outPins held mid-scan", outPins, 0);
    while (!scanDone) @(negedge clk);
    check("R9 snapshot used", outPins, 32'h1);
    @(negedge clk);
    check("R10 scanDone single cycle", scanDone, 0);
  endtask

  task automatic tOverflow();
    clearPgm();
    put(C_LD,31);
    for (int i = 0; i < 31; i++) put(C_PUSH,0);
    put(C_LD,0); put(C_PUSH,0);
    put(C_LD,31); put(C_PUSH,0);
    put(C_BOR,0); put(C_OUT,1); put(C_END,0);
    doReset();
    inPins = 32'h1;
    runScan("R7");
    check("R7 overflow flag", stackErr, 1);
    check("R7 top entry unchanged", outPins, 32'h2);
  endtask

  task automatic tUnderflow();
    clearPgm();
    put(C_LD,0); put(C_BAND,0); put(C_OUT,3); put(C_END,0);
    doReset();
    inPins = 32'h1;
    runScan("R8");
    check("R8 underflow flag", stackErr, 1);
    check("R8 accumulator kept", outPins, 32'h8);
    clearPgm();
    put(C_LD,0); put(C_OUT,4); put(C_END,0);
    runScan("R12");
    check("R12 flag sticky over clean scan", stackErr, 1);
    check("R12 clean scan result", outPins, 32'h18);
  endtask

  task automatic tStackClear();
    clearPgm();
    for (int i = 0; i < 20; i++) put(C_PUSH,0);
    put(C_END,0);
    doReset();
    runScan("R11");
    runScan("R11");
    check("R11 level reset between scans", stackErr, 0);
    check("R10 fetch restarts at zero", pgmAddr, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++; nChecks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    clearPgm();
    tResetState();
    tBranches();
    tInversions();
    tRetain();
    tSnapshot();
    tOverflow();
    tUnderflow();
    tStackClear();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule